// File: doc/BRIEF.md
# Link Test Pattern Generator

This block sits in the transmit path of a serial link and can replace live traffic with one of seven test patterns. It has two taps. One is on the 16-bit sample word that enters the link. The other is on the 10-bit code group that leaves the line encoder on its way to the PHY. A 3-bit mode field selects the pattern, or selects plain pass-through. A 2-bit select chooses the tap that receives the pattern. The tap that is not selected always carries its own input unchanged.

Both outputs are registered. Each one loads a new word on every clock edge where the advance strobe is high, and holds its value on every other edge. The pattern state advances only on advancing edges, so the pattern stays in step with the link's word rate. Whenever the mode field takes a new value, the selected pattern starts again from its first word.

Four user words allow fixed sequences to be sent. They can be cycled without end, or sent once as a four-word burst that is followed by zeros. Two pseudo-random sequences of different lengths, a checkerboard, a toggle and a ramp cover the other common link bring-up checks.

Top module: `link_tpg`

## Requirements
- R1: While reset is asserted, and until the first advancing edge after reset, both outputs are zero.
- R2: With mode 000, an advancing edge loads the sample input into the sample output and the code-group input into the code-group output.
- R3: On an edge where the advance strobe is low, both outputs hold their values. A pattern does not move forward while the strobe is low.
- R4: With any non-zero mode, injection select 01 puts the pattern on the 10-bit code-group output, and the sample output follows the sample input. Selects 00, 10 and 11 put the pattern on the 16-bit sample output, and the code-group output follows the code-group input.
- R5: Mode 001 sends a checkerboard. Word 0 is 0xAAAA and the words then alternate with 0x5555. At the 10-bit tap, the low 10 bits are used (0x2AA, then 0x155).
- R6: Mode 010 sends all ones on even words and all zeros on odd words, at the width of the selected tap.
- R7: Mode 011 sends the long pseudo-random sequence from a 23-bit shift register with polynomial x^23+x^18+1. The register is seeded with all ones. Each generated bit is the XOR of state bits 22 and 17. That bit shifts in at bit 0. One word holds the next 16 bits (or the next 10 bits at the 10-bit tap), and the earliest bit is placed at the MSB.
- R8: Mode 100 sends the short pseudo-random sequence. It works the same way as R7, but uses a 9-bit register with polynomial x^9+x^5+1 and feedback from state bits 8 and 4.
- R9: Mode 101 sends user words 0, 1, 2, 3, 0, 1, ... with one word per advancing edge.
- R10: Mode 110 sends user words 0 to 3 once each and then sends zeros. Moving into 110 from any other mode starts the burst again.
- R11: Mode 111 sends a ramp that starts at 0 and adds one per word. The ramp wraps at 2^16 at the sample tap and at 2^10 at the code-group tap.
- R12: At the 10-bit tap, a user word contributes its bits [15:6].
- R13: Any change of the mode field restarts the new pattern at word 0, even if the change happens on an edge where the advance strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Pattern mode |
| inj_sel_i | input | 2 | Tap select (01 = code group, others = sample) |
| user0_i | input | 16 | User word 0 |
| user1_i | input | 16 | User word 1 |
| user2_i | input | 16 | User word 2 |
| user3_i | input | 16 | User word 3 |
| samp_i | input | 16 | Live sample word |
| cg_i | input | 10 | Live encoded code group |
| adv_i | input | 1 | Word advance strobe |
| samp_o | output | 16 | Sample word to the link |
| cg_o | output | 10 | Code group to the PHY |

## Verification
Two corners are the hardest to reach from the ports. The first is the ramp wrap at the full 16-bit width, which needs 65536 advancing words in a single mode with no mode change in between. The second is a burst restart that is started only by a change of mode. The stimulus holds ramp mode for more than 2^16 words at the sample tap. It also runs more than 2^10 words at the code-group tap. It changes modes on edges where the strobe is low, to show that the restart does not wait for an advancing edge. Single-user mode is left and then re-entered, so the four-word burst is seen twice.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [2:0] {
    TPG_NORMAL  = 3'd0,
    TPG_CHECKER = 3'd1,
    TPG_TOGGLE  = 3'd2,
    TPG_PN_LONG = 3'd3,
    TPG_PN_SHRT = 3'd4,
    TPG_USR_REP = 3'd5,
    TPG_USR_ONE = 3'd6,
    TPG_RAMP    = 3'd7
  } tpg_mode_e;

  localparam logic [1:0] TPG_SEL_NARROW = 2'b01;
  localparam int unsigned TPG_USER_WORDS = 4;

endpackage

// File: rtl/tpg_rst_sync.sv
module tpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/tpg_prbs.sv
module tpg_prbs #(
  parameter int unsigned LEN    = 23,
  parameter int unsigned TAP    = 18,
  parameter int unsigned WIDE_W = 16,
  parameter int unsigned NARR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  input  logic              active,
  input  logic              narrow,
  output logic [WIDE_W-1:0] word_wide,
  output logic [NARR_W-1:0] word_narr
);

  logic [LEN-1:0]    state_q;
  logic [LEN-1:0]    state_d;
  logic [LEN-1:0]    chain [0:WIDE_W];
  logic [WIDE_W-1:0] bits;

  // Working state: reseeded on a restart
  assign chain[0] = restart ? {LEN{1'b1}} : state_q;

  // One shift step per output bit, earliest bit at the MSB
  for (genvar g = 0; g < WIDE_W; g++) begin : g_step
    logic fb;
    assign fb               = chain[g][LEN-1] ^ chain[g][TAP-1];
    assign chain[g+1]       = {chain[g][LEN-2:0], fb};
    assign bits[WIDE_W-1-g] = fb;
  end

  assign word_wide = bits;
  assign word_narr = bits[WIDE_W-1 -: NARR_W];

  always_comb begin
    state_d = chain[0];
    if (adv && active) begin
      state_d = narrow ? chain[NARR_W] : chain[WIDE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= {LEN{1'b1}};
    else        state_q <= state_d;
  end

endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
  import tpg_pkg::*;
#(
  parameter int unsigned SAMP_W = 16,
  parameter int unsigned CG_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  input  tpg_mode_e         mode,
  input  logic [SAMP_W-1:0] user0,
  input  logic [SAMP_W-1:0] user1,
  input  logic [SAMP_W-1:0] user2,
  input  logic [SAMP_W-1:0] user3,
  input  logic [SAMP_W-1:0] pn_long_w,
  input  logic [CG_W-1:0]   pn_long_n,
  input  logic [SAMP_W-1:0] pn_shrt_w,
  input  logic [CG_W-1:0]   pn_shrt_n,
  output logic [SAMP_W-1:0] pat_w,
  output logic [CG_W-1:0]   pat_n
);

  localparam int unsigned BURST_W = $clog2(TPG_USER_WORDS) + 1;
  localparam logic [BURST_W-1:0] BURST_END = BURST_W'(TPG_USER_WORDS);

  logic [SAMP_W-1:0]  idx_q, idx_d, idx_cur;
  logic [BURST_W-1:0] burst_q, burst_d, burst_cur;
  logic [SAMP_W-1:0]  user_rep, user_one;
  logic [SAMP_W-1:0]  chk_w, tog_w;
  logic               burst_live;

  // Word counters, cleared by a restart
  assign idx_cur   = restart ? '0 : idx_q;
  assign burst_cur = restart ? '0 : burst_q;
  assign burst_live = (burst_cur != BURST_END);

  always_comb begin
    idx_d   = idx_cur;
    burst_d = burst_cur;
    if (adv) begin
      idx_d = idx_cur + 1'b1;
      if (burst_live) burst_d = burst_cur + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      burst_q <= '0;
    end else begin
      idx_q   <= idx_d;
      burst_q <= burst_d;
    end
  end

  // Checkerboard and toggle words: bit i of even word = i odd
  for (genvar b = 0; b < SAMP_W; b++) begin : g_fixed
    assign chk_w[b] = (b % 2 == 1) ^ idx_cur[0];
    assign tog_w[b] = ~idx_cur[0];
  end

  always_comb begin
    unique case (idx_cur[1:0])
      2'd0:    user_rep = user0;
      2'd1:    user_rep = user1;
      2'd2:    user_rep = user2;
      default: user_rep = user3;
    endcase
  end

  always_comb begin
    user_one = '0;
    if (burst_live) begin
      unique case (burst_cur[1:0])
        2'd0:    user_one = user0;
        2'd1:    user_one = user1;
        2'd2:    user_one = user2;
        default: user_one = user3;
      endcase
    end
  end

  always_comb begin
    pat_w = '0;
    pat_n = '0;
    unique case (mode)
      TPG_CHECKER: begin pat_w = chk_w;     pat_n = chk_w[CG_W-1:0];   end
      TPG_TOGGLE:  begin pat_w = tog_w;     pat_n = tog_w[CG_W-1:0];   end
      TPG_PN_LONG: begin pat_w = pn_long_w; pat_n = pn_long_n;         end
      TPG_PN_SHRT: begin pat_w = pn_shrt_w; pat_n = pn_shrt_n;         end
      TPG_USR_REP: begin pat_w = user_rep;  pat_n = user_rep[SAMP_W-1 -: CG_W]; end
      TPG_USR_ONE: begin pat_w = user_one;  pat_n = user_one[SAMP_W-1 -: CG_W]; end
      TPG_RAMP:    begin pat_w = idx_cur;   pat_n = idx_cur[CG_W-1:0]; end
      default:     begin pat_w = '0;        pat_n = '0;                end
    endcase
  end

endmodule

// File: rtl/link_tpg.sv
module link_tpg
  import tpg_pkg::*;
#(
  parameter int unsigned SAMP_W    = 16,
  parameter int unsigned CG_W      = 10,
  parameter int unsigned LONG_LEN  = 23,
  parameter int unsigned LONG_TAP  = 18,
  parameter int unsigned SHRT_LEN  = 9,
  parameter int unsigned SHRT_TAP  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        inj_sel_i,
  input  logic [SAMP_W-1:0] user0_i,
  input  logic [SAMP_W-1:0] user1_i,
  input  logic [SAMP_W-1:0] user2_i,
  input  logic [SAMP_W-1:0] user3_i,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [CG_W-1:0]   cg_i,
  input  logic              adv_i,
  output logic [SAMP_W-1:0] samp_o,
  output logic [CG_W-1:0]   cg_o
);

  logic              rst_n_s;
  tpg_mode_e         mode, mode_q;
  logic              restart;
  logic              narrow;
  logic [SAMP_W-1:0] pnl_w, pns_w, pat_w;
  logic [CG_W-1:0]   pnl_n, pns_n, pat_n;
  logic [SAMP_W-1:0] samp_q, samp_d;
  logic [CG_W-1:0]   cg_q, cg_d;

  tpg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign mode    = tpg_mode_e'(mode_i);
  assign restart = (mode != mode_q);
  assign narrow  = (inj_sel_i == TPG_SEL_NARROW);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) mode_q <= TPG_NORMAL;
    else          mode_q <= mode;
  end

  tpg_prbs #(
    .LEN (LONG_LEN), .TAP (LONG_TAP), .WIDE_W (SAMP_W), .NARR_W (CG_W)
  ) u_pn_long (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .restart   (restart),
    .adv       (adv_i),
    .active    (mode == TPG_PN_LONG),
    .narrow    (narrow),
    .word_wide (pnl_w),
    .word_narr (pnl_n)
  );

  tpg_prbs #(
    .LEN (SHRT_LEN), .TAP (SHRT_TAP), .WIDE_W (SAMP_W), .NARR_W (CG_W)
  ) u_pn_shrt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .restart   (restart),
    .adv       (adv_i),
    .active    (mode == TPG_PN_SHRT),
    .narrow    (narrow),
    .word_wide (pns_w),
    .word_narr (pns_n)
  );

  tpg_seq #(
    .SAMP_W (SAMP_W), .CG_W (CG_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .restart   (restart),
    .adv       (adv_i),
    .mode      (mode),
    .user0     (user0_i),
    .user1     (user1_i),
    .user2     (user2_i),
    .user3     (user3_i),
    .pn_long_w (pnl_w),
    .pn_long_n (pnl_n),
    .pn_shrt_w (pns_w),
    .pn_shrt_n (pns_n),
    .pat_w     (pat_w),
    .pat_n     (pat_n)
  );

  // Output selection, loaded only on advancing edges
  always_comb begin
    samp_d = samp_q;
    cg_d   = cg_q;
    if (adv_i) begin
      samp_d = samp_i;
      cg_d   = cg_i;
      if (mode != TPG_NORMAL) begin
        if (narrow) cg_d   = pat_n;
        else        samp_d = pat_w;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      samp_q <= '0;
      cg_q   <= '0;
    end else begin
      samp_q <= samp_d;
      cg_q   <= cg_d;
    end
  end

  assign samp_o = samp_q;
  assign cg_o   = cg_q;

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int unsigned SAMP_W = 16,
  parameter int unsigned CG_W   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_i,
  input logic [1:0]        inj_sel_i,
  input logic [SAMP_W-1:0] samp_i,
  input logic [CG_W-1:0]   cg_i,
  input logic              adv_i,
  input logic [SAMP_W-1:0] samp_o,
  input logic [CG_W-1:0]   cg_o
);

  assert_pass_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd0 && adv_i) |=> (samp_o == $past(samp_i) && cg_o == $past(cg_i)));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> ($stable(samp_o) && $stable(cg_o)));

  assert_narrow_keeps_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 3'd0 && inj_sel_i == 2'b01 && adv_i) |=> (samp_o == $past(samp_i)));

  assert_wide_keeps_cg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 3'd0 && inj_sel_i != 2'b01 && adv_i) |=> (cg_o == $past(cg_i)));

  assert_checker_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd1 && inj_sel_i != 2'b01 && adv_i) |=>
      ($countones(samp_o) == SAMP_W / 2 && samp_o[0] != samp_o[1]));

  assert_toggle_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd2 && inj_sel_i != 2'b01 && adv_i) |=>
      ($countones(samp_o) == 0 || $countones(samp_o) == SAMP_W));

endmodule

bind link_tpg tpg_checker #(.SAMP_W (SAMP_W), .CG_W (CG_W)) u_tpg_checker (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .mode_i    (mode_i),
  .inj_sel_i (inj_sel_i),
  .samp_i    (samp_i),
  .cg_i      (cg_i),
  .adv_i     (adv_i),
  .samp_o    (samp_o),
  .cg_o      (cg_o)
);

// File: tb/link_tpg_bench.sv
`timescale 1ns/1ps
module link_tpg_bench;

  logic        clk;
  logic        rst_n;
  logic [2:0]  mode_i;
  logic [1:0]  inj_sel_i;
  logic [15:0] user0_i, user1_i, user2_i, user3_i;
  logic [15:0] samp_i;
  logic [9:0]  cg_i;
  logic        adv_i;
  logic [15:0] samp_o;
  logic [9:0]  cg_o;

  typedef struct {
    logic [15:0] samp;
    logic [9:0]  cg;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  // Reference state
  logic [2:0]  m_prev = 3'd0;
  int          idx    = 0;
  logic [22:0] l23    = '1;
  logic [8:0]  l9     = '1;
  logic [15:0] e_samp = '0;
  logic [9:0]  e_cg   = '0;

  link_tpg u_link_tpg (
    .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .inj_sel_i (inj_sel_i),
    .user0_i (user0_i), .user1_i (user1_i), .user2_i (user2_i), .user3_i (user3_i),
    .samp_i (samp_i), .cg_i (cg_i), .adv_i (adv_i), .samp_o (samp_o), .cg_o (cg_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] user_at(input int k);
    case (k % 4)
      0: return user0_i;
      1: return user1_i;
      2: return user2_i;
      default: return user3_i;
    endcase
  endfunction

  task automatic drive(input logic [2:0] m, input logic [1:0] s, input logic adv, input string tag);
    logic [15:0] pat;
    logic [15:0] mask;
    logic        nb;
    bit          narrow;
    int          w;
    exp_t        it;
    @(negedge clk);
    mode_i = m; inj_sel_i = s; adv_i = adv;
    samp_i = 16'($urandom); cg_i = 10'($urandom);
    if (m != m_prev) begin idx = 0; l23 = '1; l9 = '1; end
    m_prev = m;
    if (adv) begin
      narrow = (s == 2'b01);
      w      = narrow ? 10 : 16;
      mask   = narrow ? 16'h03FF : 16'hFFFF;
      pat    = '0;
      case (m)
        3'd1: pat = ((idx % 2 == 0) ? 16'hAAAA : 16'h5555) & mask;
        3'd2: pat = ((idx % 2 == 0) ? 16'hFFFF : 16'h0000) & mask;
        3'd3: for (int k = 0; k < w; k++) begin
                nb = l23[22] ^ l23[17]; l23 = {l23[21:0], nb}; pat = {pat[14:0], nb};
              end
        3'd4: for (int k = 0; k < w; k++) begin
                nb = l9[8] ^ l9[4]; l9 = {l9[7:0], nb}; pat = {pat[14:0], nb};
              end
        3'd5: pat = narrow ? {6'd0, user_at(idx) >> 6} : user_at(idx);
        3'd6: if (idx < 4) pat = narrow ? {6'd0, user_at(idx) >> 6} : user_at(idx);
        3'd7: pat = 16'(idx) & mask;
        default: pat = '0;
      endcase
      e_samp = samp_i;
      e_cg   = cg_i;
      if (m != 3'd0) begin
        if (narrow) e_cg = pat[9:0];
        else        e_samp = pat;
      end
      idx++;
    end
    it.samp = e_samp; it.cg = e_cg; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: one expected item per clock once driving begins
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() != 0) begin
        it = exp_q.pop_front();
        total++;
        if (samp_o !== it.samp || cg_o !== it.cg) begin
          bad++;
          $display("FAIL %s: samp=%h cg=%h expected samp=%h cg=%h",
                   it.tag, samp_o, cg_o, it.samp, it.cg);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_i = 3'd0; inj_sel_i = 2'b00; adv_i = 1'b0;
    samp_i = '0; cg_i = '0;
    user0_i = 16'hC3A5; user1_i = 16'h1F80; user2_i = 16'hFFC0; user3_i = 16'h0E71;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (samp_o !== 16'h0 || cg_o !== 10'h0) begin
      bad++; $display("FAIL R1 in reset: samp=%h cg=%h expected 0 0", samp_o, cg_o);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    total++;
    if (samp_o !== 16'h0 || cg_o !== 10'h0) begin
      bad++; $display("FAIL R1 after reset: samp=%h cg=%h expected 0 0", samp_o, cg_o);
    end

    // R2: pass-through
    for (int i = 0; i < 6; i++) drive(3'd0, 2'(i % 4), 1'b1, "R2");
    // R3: hold while idle, then ramp starts at 0 despite idle cycles
    for (int i = 0; i < 3; i++) drive(3'd0, 2'b00, 1'b0, "R3");
    for (int i = 0; i < 3; i++) drive(3'd7, 2'b00, 1'b0, "R3");
    for (int i = 0; i < 4; i++) drive(3'd7, 2'b00, 1'b1, "R3");
    drive(3'd7, 2'b00, 1'b0, "R3");
    drive(3'd7, 2'b00, 1'b1, "R3");
    // R4: tap select on a running ramp
    for (int i = 0; i < 4; i++) drive(3'd7, 2'b01, 1'b1, "R4");
    for (int i = 0; i < 4; i++) drive(3'd7, 2'(2 + i % 2), 1'b1, "R4");
    // R5: checkerboard at both taps
    for (int i = 0; i < 8; i++) drive(3'd1, 2'b00, 1'b1, "R5");
    for (int i = 0; i < 4; i++) drive(3'd1, 2'b01, 1'b1, "R5");
    // R6: toggle
    for (int i = 0; i < 6; i++) drive(3'd2, 2'b10, 1'b1, "R6");
    for (int i = 0; i < 4; i++) drive(3'd2, 2'b01, 1'b1, "R6");
    // R7: long PN, wide then narrow after a restart
    for (int i = 0; i < 40; i++) drive(3'd3, 2'b00, 1'b1, "R7");
    drive(3'd0, 2'b00, 1'b1, "R7");
    for (int i = 0; i < 30; i++) drive(3'd3, 2'b01, 1'b1, "R7");
    // R8: short PN spanning more than one period
    for (int i = 0; i < 70; i++) drive(3'd4, 2'b11, 1'b1, "R8");
    drive(3'd0, 2'b00, 1'b0, "R8");
    for (int i = 0; i < 60; i++) drive(3'd4, 2'b01, 1'b1, "R8");
    // R9 and R12: repeating user words
    for (int i = 0; i < 10; i++) drive(3'd5, 2'b00, 1'b1, "R9");
    for (int i = 0; i < 6; i++) drive(3'd5, 2'b01, 1'b1, "R12");
    // R10: single burst, leave and re-enter
    for (int i = 0; i < 8; i++) drive(3'd6, 2'b00, 1'b1, "R10");
    for (int i = 0; i < 2; i++) drive(3'd7, 2'b00, 1'b1, "R10");
    for (int i = 0; i < 7; i++) drive(3'd6, 2'b01, 1'b1, "R10");
    // R13: mode change on idle edges restarts
    for (int i = 0; i < 3; i++) drive(3'd1, 2'b00, 1'b1, "R13");
    drive(3'd2, 2'b00, 1'b0, "R13");
    drive(3'd1, 2'b00, 1'b0, "R13");
    for (int i = 0; i < 3; i++) drive(3'd1, 2'b00, 1'b1, "R13");
    // R11: ramp wrap at both widths
    drive(3'd0, 2'b00, 1'b1, "R11");
    for (int i = 0; i < 1030; i++) drive(3'd7, 2'b01, 1'b1, "R11");
    drive(3'd0, 2'b00, 1'b1, "R11");
    for (int i = 0; i < 65540; i++) drive(3'd7, 2'b00, 1'b1, "R11");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule